// File: doc/BRIEF.md
# Exception Ordering Sequencer

At every instruction boundary this block decides which exceptions are serviced and in what order. It does this for three of them: the trap forced by the instruction, the single-step trace, and the pending interrupt. The instruction pipeline strobes `insn_done` once per finished instruction. On that strobe it supplies a code for how the instruction ended, the trace-enable bit, a trap request with its vector number, and a pending-interrupt flag. The block samples all of these on the strobe and decides which exceptions apply. It then presents them to a downstream stacking engine one at a time, each on a valid/ready handshake. The order is always trap first, then trace, then interrupt.

`busy` is high while the block is working through a boundary. The next instruction must not start until `busy` is low. While `busy` is high, the block ignores any further strobe and any change on the sampled inputs.

The state machine has four states. `ST_IDLE` waits for a strobe. `ST_TRAP`, `ST_TRACE` and `ST_IRQ` each present one request.

The transitions are:
- idle-to-service, on a strobe with at least one exception due. The block moves to the highest-ranked due state.
- idle-hold, on a strobe with nothing due.
- stall, when a service state is not accepted. The block stays in that state.
- advance, on acceptance. The block moves to the next remaining due state.
- retire, on acceptance of the last due request. The block returns to `ST_IDLE`.

Top module: `exc_order_seq`

## Requirements
- R1: After reset, `req_valid` and `busy` are 0.
- R2: A trace request is produced only when trace-enable is 1 at the strobe and the end code is 0 (executed). The other end codes are: 1 illegal, 2 privileged, 3 preempted by an interrupt, 4 reset abort, 5 bus-error abort, 6 address-error abort, and 7 reserved. None of these ever produces a trace request.
- R3: A trap request is produced only when `trap_req` is 1 at the strobe and the end code is 0. Its vector is the `trap_vec` value sampled at the strobe.
- R4: Requests of one boundary are issued in the order trap (`req_kind`=1), then trace (`req_kind`=2), then interrupt (`req_kind`=3).
- R5: An interrupt request is produced when `irq_pend` is 1 at the strobe and the end code is 0, 1, 2 or 3. For code 3 the interrupt is the only request. The trace vector is `TRACE_VEC` (default 9) and the interrupt vector is `IRQ_VEC` (default 30).
- R6: While `req_valid` is 1 and `req_ready` is 0, the request (`req_vec` and `req_kind`) is held unchanged. After an acceptance, the next request of the boundary is valid in the following cycle.
- R7: The first request of a boundary is valid in the cycle after the strobe edge. `busy` rises in that cycle when any request is due. `busy` falls in the cycle after the last acceptance.
- R8: A strobe that arrives while `busy` is 1 is ignored. It neither adds nor removes requests.
- R9: Changes to trace-enable, `trap_req`, `trap_vec` or `irq_pend` after the strobe do not change the decisions already taken.
- R10: End codes 4 to 7 produce no request, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_done | input | 1 | Instruction-complete strobe, one cycle |
| end_code | input | 3 | How the instruction ended (see R2) |
| trace_en | input | 1 | Trace-enable bit |
| trap_req | input | 1 | Trap forced by the instruction |
| trap_vec | input | VEC_W | Vector number for the trap |
| irq_pend | input | 1 | Interrupt pending |
| req_valid | output | 1 | Service request valid |
| req_ready | input | 1 | Stacking engine accepts the request |
| req_kind | output | 2 | 1 trap, 2 trace, 3 interrupt |
| req_vec | output | VEC_W | Vector number of the request |
| busy | output | 1 | Boundary in progress; next instruction must wait |

## Verification
The bench sweeps all 64 combinations of end code, trace-enable, trap request and pending interrupt. For each one it computes the expected list of requests from R2, R3 and R5. The first request is due one clock after the strobe edge. Each later request is due one clock after the acceptance edge of the one before it. `busy` is due low one clock after the last acceptance. All checks are taken on the falling edge that follows the edge where each result is due. Each request is stalled for a varying number of cycles, and it is checked on every stalled cycle. During the stalls the bench changes the sampled inputs and sends an extra strobe, so that R8 and R9 show up as the expected sequence being left unchanged.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [2:0] {
        END_EXEC     = 3'd0,
        END_ILLEGAL  = 3'd1,
        END_PRIV     = 3'd2,
        END_PREEMPT  = 3'd3,
        END_RST_ABT  = 3'd4,
        END_BUS_ABT  = 3'd5,
        END_ADR_ABT  = 3'd6,
        END_RESERVED = 3'd7
    } end_code_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_TRAP  = 2'd1,
        KIND_TRACE = 2'd2,
        KIND_IRQ   = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRAP,
        ST_TRACE,
        ST_IRQ
    } seq_state_e;

    typedef struct packed {
        logic trap;
        logic trace;
        logic irq;
    } pend_t;

endpackage

// File: rtl/exc_eligibility.sv
module exc_eligibility
    import exc_seq_pkg::*;
(
    input  logic [2:0] end_code,
    input  logic       trace_en,
    input  logic       trap_req,
    input  logic       irq_pend,
    output pend_t      elig
);
    logic executed;
    logic irq_ok;

    always_comb begin
        executed = (end_code == END_EXEC);
        // Interrupts are still taken after faults of the instruction itself,
        // but not after aborts, which are handled by a higher-ranked path.
        irq_ok = (end_code == END_EXEC)    || (end_code == END_ILLEGAL) ||
                 (end_code == END_PRIV)    || (end_code == END_PREEMPT);
        elig.trap  = executed && trap_req;
        elig.trace = executed && trace_en;
        elig.irq   = irq_ok && irq_pend;
    end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_seq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  pend_t            elig,
    input  logic [VEC_W-1:0] trap_vec_in,
    input  logic             req_ready,
    output seq_state_e       state,
    output logic [VEC_W-1:0] trap_vec_q,
    output logic             req_valid,
    output logic [1:0]       req_kind,
    output logic             busy
);
    seq_state_e       state_n;
    pend_t            pend_q, pend_n;
    logic [VEC_W-1:0] tvec_n;
    logic             accept;

    function automatic seq_state_e pick(input pend_t p);
        if (p.trap)       return ST_TRAP;
        else if (p.trace) return ST_TRACE;
        else if (p.irq)   return ST_IRQ;
        else              return ST_IDLE;
    endfunction

    function automatic pend_t drop(input pend_t p);
        pend_t r;
        r = p;
        if (p.trap)       r.trap  = 1'b0;
        else if (p.trace) r.trace = 1'b0;
        else              r.irq   = 1'b0;
        return r;
    endfunction

    assign accept = req_valid && req_ready;

    // next-state and pending-set logic
    always_comb begin
        state_n = state;
        pend_n  = pend_q;
        tvec_n  = trap_vec_q;
        unique case (state)
            ST_IDLE: begin
                if (insn_done) begin
                    state_n = pick(elig);
                    pend_n  = drop(elig);
                    tvec_n  = trap_vec_in;
                end
            end
            ST_TRAP, ST_TRACE, ST_IRQ: begin
                if (accept) begin
                    state_n = pick(pend_q);
                    pend_n  = drop(pend_q);
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pend_q     <= '0;
            trap_vec_q <= '0;
        end else begin
            state      <= state_n;
            pend_q     <= pend_n;
            trap_vec_q <= tvec_n;
        end
    end

    // outputs
    always_comb begin
        req_valid = 1'b0;
        req_kind  = KIND_NONE;
        busy      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_TRAP:  begin req_valid = 1'b1; busy = 1'b1; req_kind = KIND_TRAP;  end
            ST_TRACE: begin req_valid = 1'b1; busy = 1'b1; req_kind = KIND_TRACE; end
            ST_IRQ:   begin req_valid = 1'b1; busy = 1'b1; req_kind = KIND_IRQ;   end
            default:  ;
        endcase
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_kind)));

    assert_trace_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACE && req_ready) |=> (state == ST_IRQ || state == ST_IDLE));

    assert_irq_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IRQ && req_ready) |=> (state == ST_IDLE));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_ready) |=> ($stable(pend_q) && $stable(trap_vec_q)));

    assert_trap_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && insn_done && elig.trap) |=> (state == ST_TRAP));

    assert_nothing_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && insn_done && elig == '0) |=> !busy);
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_seq_pkg::*;
#(
    parameter int             VEC_W     = 8,
    parameter logic [VEC_W-1:0] TRACE_VEC = 9,
    parameter logic [VEC_W-1:0] IRQ_VEC   = 30
) (
    input  seq_state_e       state,
    input  logic [VEC_W-1:0] trap_vec_q,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        unique case (state)
            ST_TRAP:  vec = trap_vec_q;
            ST_TRACE: vec = TRACE_VEC;
            ST_IRQ:   vec = IRQ_VEC;
            default:  vec = '0;
        endcase
    end
endmodule

// File: rtl/exc_order_seq.sv
module exc_order_seq
    import exc_seq_pkg::*;
#(
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] TRACE_VEC = 9,
    parameter logic [VEC_W-1:0] IRQ_VEC   = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic [2:0]       end_code,
    input  logic             trace_en,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             irq_pend,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [1:0]       req_kind,
    output logic [VEC_W-1:0] req_vec,
    output logic             busy
);
    pend_t            elig;
    seq_state_e       state;
    logic [VEC_W-1:0] trap_vec_q;

    exc_eligibility u_elig (
        .end_code (end_code),
        .trace_en (trace_en),
        .trap_req (trap_req),
        .irq_pend (irq_pend),
        .elig     (elig)
    );

    exc_seq_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done   (insn_done),
        .elig        (elig),
        .trap_vec_in (trap_vec),
        .req_ready   (req_ready),
        .state       (state),
        .trap_vec_q  (trap_vec_q),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .busy        (busy)
    );

    exc_vec_sel #(.VEC_W(VEC_W), .TRACE_VEC(TRACE_VEC), .IRQ_VEC(IRQ_VEC)) u_vec (
        .state      (state),
        .trap_vec_q (trap_vec_q),
        .vec        (req_vec)
    );

    assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(req_vec));

    assert_abort_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && end_code != 3'd0) |=> (req_kind != 2'd2 && req_kind != 2'd1));
endmodule

// File: tb/sim_exc_order_seq.sv
module sim_exc_order_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TRACE_V = 9;
    localparam int IRQ_V   = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done = 1'b0;
    logic [2:0] end_code = 3'd0;
    logic       trace_en = 1'b0;
    logic       trap_req = 1'b0;
    logic [7:0] trap_vec = 8'd0;
    logic       irq_pend = 1'b0;
    logic       req_valid;
    logic       req_ready = 1'b0;
    logic [1:0] req_kind;
    logic [7:0] req_vec;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_order_seq u0 (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .end_code(end_code),
        .trace_en(trace_en), .trap_req(trap_req), .trap_vec(trap_vec),
        .irq_pend(irq_pend), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_vec(req_vec), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int idx, input logic [2:0] code,
                            input logic tr, input logic tp, input logic ip);
        int kinds[3];
        int vecs[3];
        int n = 0;
        logic [7:0] tv;
        tv = 8'd32 + 8'(idx % 16);
        // R3 trap, R2 trace, R5 interrupt eligibility, in R4 order
        if (code == 3'd0 && tp) begin kinds[n] = 1; vecs[n] = int'(tv); n++; end
        if (code == 3'd0 && tr) begin kinds[n] = 2; vecs[n] = TRACE_V;  n++; end
        if (code <= 3'd3 && ip) begin kinds[n] = 3; vecs[n] = IRQ_V;    n++; end

        @(negedge clk);
        insn_done = 1'b1; end_code = code; trace_en = tr; trap_req = tp;
        irq_pend = ip; trap_vec = tv; req_ready = 1'b0;
        @(negedge clk);
        // R9: disturb sampled inputs after the strobe
        insn_done = 1'b0; trace_en = ~tr; trap_req = ~tp; irq_pend = ~ip; trap_vec = 8'hFF;
        chk(busy == (n > 0), (code >= 3'd4) ? "R10" : "R7", "busy after strobe", int'(busy), int'(n > 0));
        for (int i = 0; i < n; i++) begin
            int stalls = (idx + i) % 3;
            for (int s = 0; s < stalls; s++) begin
                chk(req_valid == 1'b1, "R6", "valid in stall", int'(req_valid), 1);
                chk(int'(req_kind) == kinds[i], "R4", "kind in stall", int'(req_kind), kinds[i]);
                chk(int'(req_vec) == vecs[i], "R6", "vec in stall", int'(req_vec), vecs[i]);
                if (s == 0) begin
                    // R8: strobe while busy must be ignored
                    insn_done = 1'b1; end_code = 3'd0; trace_en = 1'b1; trap_req = 1'b1; irq_pend = 1'b1;
                end
                @(negedge clk);
                insn_done = 1'b0;
            end
            chk(req_valid == 1'b1, "R7", "valid", int'(req_valid), 1);
            chk(int'(req_kind) == kinds[i], "R4", "kind", int'(req_kind), kinds[i]);
            chk(int'(req_vec) == vecs[i], (kinds[i] == 1) ? "R3" : "R5", "vec", int'(req_vec), vecs[i]);
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
        end
        chk(req_valid == 1'b0, (n == 0) ? "R2" : "R8", "valid after boundary", int'(req_valid), 0);
        chk(busy == 1'b0, "R7", "busy after boundary", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R1", "reset valid", int'(req_valid), 0);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R1", "valid after reset release", int'(req_valid), 0);
        for (int c = 0; c < 64; c++) begin
            run_case(c, 3'(c >> 3), c[2], c[1], c[0]);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule